// File: doc/BRIEF.md
# Two-Target Interrupt Controller Bank

This block collects 32 level-sensitive interrupt sources and turns them into request outputs for two consumers: a main CPU and a coprocessor. Software can also force any line to look pending, which re-raises a request after its source has gone idle, and removes the forced request again when it finishes handling the interrupt. Each consumer has its own enable mask and its own class mask. The class mask sends each enabled, pending line either to that consumer's normal request (IRQ) or to its fast request (FIQ).

The block sits on a simple register bus with an address, a write strobe, write data and a combinational read-data path. The enable masks and the force mask each have a plain register and two write-only aliases. Writing to the set alias turns on the bits where the data is 1. Writing to the clear alias turns off the bits where the data is 1. Data bits that are 0 have no effect. A single write can therefore disable every line, and a saved mask can be restored by clearing all bits and then setting the saved ones. A read-only status word shows which CPU lines are pending on the fast path.

Top module: `intc_bank`

## Requirements
- R1: After reset, every readable register reads 0 and all four request outputs (cpu_irq, cpu_fiq, cop_irq, cop_fiq) are low, whatever the sources do.
- R2: Reads return the current value at these offsets: force 0x14, CPU enable 0x20, CPU class 0x2C, coprocessor enable 0x30, coprocessor class 0x3C. Reads of the alias offsets (0x18, 0x1C, 0x24, 0x28, 0x34, 0x38) and of any other offset return 0.
- R3: A write to the set alias (0x24 for the CPU enable, 0x34 for the coprocessor enable) turns on the enable bits where the data is 1 and leaves the other bits unchanged.
- R4: A write to the clear alias (0x28 for the CPU, 0x38 for the coprocessor) turns off the enable bits where the data is 1 and leaves the other bits unchanged. Writing all ones clears the whole mask in one access.
- R5: A write to 0x18 sets force bits and a write to 0x1C clears force bits, with the same ones-only rule. While a line's force bit is 1, the line counts as active even when its source is low.
- R6: For each target, a line is pending when it is active (its source is high or its force bit is 1) and its enable bit is 1. IRQ is the OR of pending lines whose class bit is 0. FIQ is the OR of pending lines whose class bit is 1.
- R7: The CPU and the coprocessor keep separate enable and class masks. Writes to one target's registers leave the other target's registers and outputs unchanged.
- R8: Offset 0x08 reads the CPU lines that are pending and whose CPU class bit is 1, one bit per line. Writes to 0x08 have no effect.
- R9: A write to a plain register offset (0x14, 0x20, 0x2C, 0x30, 0x3C) loads all 32 bits from the write data.
- R10: A write takes effect at the clock edge that samples it, and its result shows on the read data and on the outputs during the next cycle. A change on a source reaches the outputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 32 | Level-sensitive interrupt sources, one bit per line |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 1 | Normal request to the main CPU |
| cpu_fiq | output | 1 | Fast request to the main CPU |
| cop_irq | output | 1 | Normal request to the coprocessor |
| cop_fiq | output | 1 | Fast request to the coprocessor |

## Verification
On every cycle, the assertions check the following. A set-alias write only adds bits and a clear-alias write only removes bits, and no other bit changes. A register with no write holds its value. A target with an empty enable mask raises no request. A target whose lines are all in the fast class never raises IRQ. The bench compares the outputs and the read data against its own model in every cycle. Only the bench's scenarios can show the rest: the full value of each output word, the independence of the two targets, forcing a line whose source is idle, the zero reads at alias and unmapped offsets, and the status word at 0x08.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LINES  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_VFIQ  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FRC   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CPU_E = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CPU_C = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_COP_E = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_COP_C = 8'h3C;
  localparam logic [ADDR_W-1:0] STEP_SET  = 8'h04;
  localparam logic [ADDR_W-1:0] STEP_CLR  = 8'h08;

  function automatic logic [LINES-1:0] mask_next(
    input logic [LINES-1:0] cur, input logic [LINES-1:0] wd,
    input logic ld, input logic st, input logic cl);
    logic [LINES-1:0] r;
    r = cur;
    if (ld) r = wd;
    if (st) r = cur | wd;
    if (cl) r = cur & ~wd;
    return r;
  endfunction

  function automatic logic [LINES-1:0] pend_vec(
    input logic [LINES-1:0] srcv, input logic [LINES-1:0] frc,
    input logic [LINES-1:0] en);
    return (srcv | frc) & en;
  endfunction
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg
  import intc_pkg::*;
#(
  parameter int W = LINES,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter bit HAS_ALIAS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);
  localparam logic [ADDR_W-1:0] SET_OFF = BASE + STEP_SET;
  localparam logic [ADDR_W-1:0] CLR_OFF = BASE + STEP_CLR;

  logic hit_ld, hit_set, hit_clr;
  assign hit_ld = we && (addr == BASE);

  generate
    if (HAS_ALIAS) begin : g_alias
      assign hit_set = we && (addr == SET_OFF);
      assign hit_clr = we && (addr == CLR_OFF);

      a_r3_set_only_adds: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> (((q & $past(wdata)) == $past(wdata)) &&
                     ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));
      a_r4_clr_only_removes: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> (((q & $past(wdata)) == '0) &&
                     ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));
    end else begin : g_plain
      assign hit_set = 1'b0;
      assign hit_clr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= mask_next(q, wdata, hit_ld, hit_set, hit_clr);
  end

  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/intc_target.sv
module intc_target
  import intc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] EN_OFF  = OFF_CPU_E,
  parameter logic [ADDR_W-1:0] CLS_OFF = OFF_CPU_C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  active,
  output logic [LINES-1:0]  en_q,
  output logic [LINES-1:0]  cls_q,
  output logic [LINES-1:0]  fast_pend,
  output logic              irq,
  output logic              fiq
);
  logic [LINES-1:0] pend;

  intc_setclr_reg #(.W(LINES), .BASE(EN_OFF), .HAS_ALIAS(1'b1)) u_en (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .q(en_q));

  intc_setclr_reg #(.W(LINES), .BASE(CLS_OFF), .HAS_ALIAS(1'b0)) u_cls (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .q(cls_q));

  assign pend      = pend_vec(active, '0, en_q);
  assign fast_pend = pend & cls_q;
  assign irq       = |(pend & ~cls_q);
  assign fiq       = |fast_pend;

  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq && !fiq));
  a_r6_all_fast_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == '1) |-> !irq);
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  output logic              cpu_irq,
  output logic              cpu_fiq,
  output logic              cop_irq,
  output logic              cop_fiq
);
  localparam int NT = 2;

  logic [LINES-1:0] frc_q, active;
  logic [LINES-1:0] en_v [NT];
  logic [LINES-1:0] cls_v [NT];
  logic [LINES-1:0] fp_v [NT];
  logic [NT-1:0]    irq_v, fiq_v;

  intc_setclr_reg #(.W(LINES), .BASE(OFF_FRC), .HAS_ALIAS(1'b1)) u_frc (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(frc_q));

  assign active = src | frc_q;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_tgt
      localparam logic [ADDR_W-1:0] EO = (t == 0) ? OFF_CPU_E : OFF_COP_E;
      localparam logic [ADDR_W-1:0] CO = (t == 0) ? OFF_CPU_C : OFF_COP_C;
      intc_target #(.EN_OFF(EO), .CLS_OFF(CO)) u_t (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .active(active), .en_q(en_v[t]),
        .cls_q(cls_v[t]), .fast_pend(fp_v[t]), .irq(irq_v[t]), .fiq(fiq_v[t]));
    end
  endgenerate

  assign cpu_irq = irq_v[0];
  assign cpu_fiq = fiq_v[0];
  assign cop_irq = irq_v[1];
  assign cop_fiq = fiq_v[1];

  always_comb begin
    unique case (bus_addr)
      OFF_VFIQ:  bus_rdata = fp_v[0];
      OFF_FRC:   bus_rdata = frc_q;
      OFF_CPU_E: bus_rdata = en_v[0];
      OFF_CPU_C: bus_rdata = cls_v[0];
      OFF_COP_E: bus_rdata = en_v[1];
      OFF_COP_C: bus_rdata = cls_v[1];
      default:   bus_rdata = '0;
    endcase
  end

  a_r8_status_within_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_VFIQ) |-> ((bus_rdata & ~cls_v[0]) == '0));
  a_r6_fiq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_VFIQ && cpu_fiq) |-> (bus_rdata != '0));
endmodule

// File: tb/intc_bank_tb.sv
module intc_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] m_frc = '0;
  logic [31:0] m_en [2];
  logic [31:0] m_cls [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .src(src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq), .cop_fiq(cop_fiq));

  // Behavioural reference: registers updated at the write edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_frc <= 0; m_en[0] <= 0; m_en[1] <= 0; m_cls[0] <= 0; m_cls[1] <= 0;
    end else if (bus_we) begin
      case (bus_addr)
        8'h14: m_frc <= bus_wdata;
        8'h18: m_frc <= m_frc | bus_wdata;
        8'h1C: m_frc <= m_frc & ~bus_wdata;
        8'h20: m_en[0] <= bus_wdata;
        8'h24: m_en[0] <= m_en[0] | bus_wdata;
        8'h28: m_en[0] <= m_en[0] & ~bus_wdata;
        8'h2C: m_cls[0] <= bus_wdata;
        8'h30: m_en[1] <= bus_wdata;
        8'h34: m_en[1] <= m_en[1] | bus_wdata;
        8'h38: m_en[1] <= m_en[1] & ~bus_wdata;
        8'h3C: m_cls[1] <= bus_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] live(input int t);
    return (src | m_frc) & m_en[t];
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h08: return live(0) & m_cls[0];
      8'h14: return m_frc;
      8'h20: return m_en[0];
      8'h2C: return m_cls[0];
      8'h30: return m_en[1];
      8'h3C: return m_cls[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R6, R2, R10).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 outputs", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq},
          {28'h0, |(live(0) & ~m_cls[0]), |(live(0) & m_cls[0]),
                  |(live(1) & ~m_cls[1]), |(live(1) & m_cls[1])});
      chk("R2 rdata", bus_rdata, exp_read(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic outs(input logic [3:0] exp, input string tag);
    @(negedge clk);
    chk(tag, {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, {28'h0, exp});
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    logic [7:0] offs [12];
    offs = '{8'h08, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
             8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C};
    src = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    outs(4'b0000, "R1 outputs after reset");
    rd(8'h20, 32'h0, "R1 cpu enable");
    rd(8'h14, 32'h0, "R1 force");
    rd(8'h3C, 32'h0, "R1 cop class");
    src = 32'h0;
    // R3 / R10: set alias, then visible next cycle
    wr(8'h24, 32'h0000_00F0);
    rd(8'h20, 32'h0000_00F0, "R3 set alias");
    wr(8'h24, 32'h0000_0F00);
    rd(8'h20, 32'h0000_0FF0, "R3 set keeps other bits");
    // R2: alias reads zero
    rd(8'h24, 32'h0, "R2 set alias reads zero");
    rd(8'h28, 32'h0, "R2 clear alias reads zero");
    rd(8'h44, 32'h0, "R2 unmapped reads zero");
    // R6 / R10: source is combinational
    src = 32'h0000_0010;
    outs(4'b1000, "R6 cpu irq from source");
    src = 32'h0000_0001;
    outs(4'b0000, "R6 disabled line ignored");
    // R9: class plain write, FIQ routing
    wr(8'h2C, 32'h0000_0001);
    src = 32'h0000_0010;
    outs(4'b1000, "R9 class bit 0 stays irq");
    wr(8'h2C, 32'h0000_0010);
    outs(4'b0100, "R6 class bit 1 routes fiq");
    rd(8'h08, 32'h0000_0010, "R8 status bit");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_0010, "R8 write has no effect");
    rd(8'h2C, 32'h0000_0010, "R8 write leaves class");
    // R4: clear alias
    wr(8'h28, 32'h0000_0030);
    rd(8'h20, 32'h0000_0FC0, "R4 clear alias");
    outs(4'b0000, "R4 cleared line quiet");
    // R5: force with idle source
    src = 32'h0;
    wr(8'h18, 32'h0000_0100);
    outs(4'b1000, "R5 forced line pending");
    rd(8'h14, 32'h0000_0100, "R5 force readback");
    wr(8'h1C, 32'h0000_0100);
    outs(4'b0000, "R5 force cleared");
    // R7: coprocessor independence
    wr(8'h30, 32'h8000_0000);
    wr(8'h3C, 32'h8000_0000);
    src = 32'h8000_0000;
    outs(4'b0001, "R7 cop fiq only");
    rd(8'h20, 32'h0000_0FC0, "R7 cpu enable untouched");
    wr(8'h34, 32'h0000_0100);
    src = 32'h8000_0100;
    outs(4'b1011, "R7 both targets");
    // R4: clear all in one access
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R4 clear all cpu");
    wr(8'h38, 32'hFFFF_FFFF);
    outs(4'b0000, "R4 clear all cop");
    // Restore: write saved mask to set alias
    wr(8'h24, 32'h0000_0100);
    rd(8'h20, 32'h0000_0100, "R3 restore via set alias");
    wr(8'h20, 32'h1234_5678);
    rd(8'h20, 32'h1234_5678, "R9 plain load");
    wr(8'h14, 32'h0000_0003);
    rd(8'h14, 32'h0000_0003, "R9 force plain load");
    // Pseudo-random traffic, compared every cycle by the model
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      src = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      @(posedge clk); #1;
      bus_addr = offs[lfsr[3:0] % 12];
      bus_wdata = {lfsr[7:0], lfsr[31:8]};
      bus_we = lfsr[4];
    end
    @(posedge clk); #1;
    bus_we = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule